// File: doc/BRIEF.md
# Differential SAR Conversion Controller

This block is the digital sequencer of a charge-redistribution successive-approximation converter. The converter has two matched binary-weighted capacitor arrays, one on each side of a comparator. While the converter is idle, the block holds it in the sampling configuration. When the convert input falls, the block opens the comparator-side switches. It then takes both arrays off the analog inputs and searches the code one bit at a time, starting from the most significant bit.

On every trial cycle the block reads one comparator decision. An overshoot clears the tentative bit; otherwise the bit stays set. When the last bit is decided, the block writes a two's-complement result, drops `busy` and returns to sampling. The result always belongs to the sample that was just taken.

Top module: `sar_diff_ctrl`

## Requirements
- R1: After the active-low synchronous reset: `busy`=0, `samp_close`=1, `in_connect`=1, `arr_p`=0, `arr_n`=0 and `result`=0.
- R2: A high-to-low transition of `conv_n`, seen at a clock edge while idle, starts a conversion. In the first busy cycle `samp_close`=0 and `in_connect` is still 1.
- R3: In the cycle after that, `in_connect` goes to 0 and the first trial presents only the MSB on `arr_p` (16'h8000).
- R4: On each trial the tentative bit is cleared if `cmp_in`=1 (trial overshoots) and kept if `cmp_in`=0. The decision shows in `arr_p` on the next trial.
- R5: While `in_connect`=0, `arr_n` is the bitwise complement of `arr_p`. While `in_connect`=1, both vectors are 0.
- R6: `busy` stays high for exactly 17 cycles (1 setup cycle plus 16 trials). It falls in the same cycle that `result` takes the new code, and `result` does not change while idle.
- R7: `result` is the two's complement of the differential input in LSBs: 0 gives 16'h0000, +1 gives 16'h0001, −1 gives 16'hFFFF. Bit 15 is the inverted MSB of the internal offset-binary code.
- R8: Inputs at or above +32767 LSB give 16'h7FFF. Inputs at or below −32768 LSB give 16'h8000.
- R9: A `conv_n` fall while `busy`=1 has no effect on timing or result. Holding `conv_n` low after a conversion starts no new one.
- R10: `samp_close`=1 and `in_connect`=1 exactly when `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_n | input | 1 | Convert request; a falling edge starts a conversion |
| cmp_in | input | 1 | Comparator decision, 1 = present trial overshoots |
| samp_close | output | 1 | Comparator-side switches of both arrays closed to ground |
| in_connect | output | 1 | Element switches connected to the analog inputs |
| arr_p | output | 16 | Positive-array element select, 1 = REF, 0 = GND |
| arr_n | output | 16 | Negative-array element select, complement of `arr_p` |
| busy | output | 1 | Conversion in progress |
| result | output | 16 | Last two's-complement conversion result |

## Verification
A wrong bit counter or phase shows up at once as a `busy` width other than 17 cycles, or as switch outputs out of order around the start of a conversion. A wrong keep or clear decision shows up on `arr_p` one trial later, because the next trial pattern then differs from the arithmetic binary search. A formatting error shows up only when `busy` falls, as a wrong code for a given differential input, most clearly at zero, at ±1 LSB and in saturation.

// File: rtl/sar_pkg.sv
// Shared types for the differential SAR controller.
package sar_pkg;
    // Converter phase: sampling, switch-open setup, bit trials
    typedef enum logic [1:0] {
        PH_ACQ   = 2'd0,
        PH_OPEN  = 2'd1,
        PH_TRIAL = 2'd2
    } sar_phase_e;
endpackage

// File: rtl/sar_fall_detect.sv
// Detects a high-to-low transition of the convert request.
// Assumes conv_n is already synchronous to clk.
module sar_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_n,
    output logic fall
);
    logic prev_q;

    // Remember the last sampled level; reset to high so that no false edge appears
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= conv_n;
    end

    assign fall = prev_q & ~conv_n;
endmodule

// File: rtl/sar_sequencer.sv
// Phase state machine and bit-trial counter.
// Assumes the start pulse lasts one cycle; it is ignored outside acquisition.
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output sar_phase_e       phase,
    output logic [IDX_W-1:0] bit_idx,
    output logic             last_trial
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

    sar_phase_e       phase_q;
    logic [IDX_W-1:0] idx_q;

    // Advance the phase and step the trial index from MSB down to LSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_ACQ;
            idx_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_ACQ:   if (start) phase_q <= PH_OPEN;
                PH_OPEN: begin
                    phase_q <= PH_TRIAL;
                    idx_q   <= TOP_IDX;
                end
                PH_TRIAL: begin
                    if (idx_q == '0) phase_q <= PH_ACQ;
                    else             idx_q   <= idx_q - 1'b1;
                end
                default:  phase_q <= PH_ACQ;
            endcase
        end
    end

    assign phase      = phase_q;
    assign bit_idx    = idx_q;
    assign last_trial = (phase_q == PH_TRIAL) && (idx_q == '0);
endmodule

// File: rtl/sar_approx_reg.sv
// Successive-approximation register: sets the trial bit tentatively and keeps
// or clears it from the comparator. Assumes cmp_in is valid within the trial cycle.
module sar_approx_reg
    import sar_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sar_phase_e       phase,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] trial_vec,
    output logic [WIDTH-1:0] final_code
);
    logic [WIDTH-1:0] code_q;
    logic [WIDTH-1:0] onehot;

    assign onehot = {{(WIDTH-1){1'b0}}, 1'b1} << bit_idx;

    // Clear at setup; record the decision for the bit under trial
    always_ff @(posedge clk) begin
        if (!rst_n)                  code_q <= '0;
        else if (phase == PH_OPEN)   code_q <= '0;
        else if (phase == PH_TRIAL)  code_q[bit_idx] <= ~cmp_in;
    end

    // Present the decided bits plus the tentative one during trials
    always_comb begin
        if (phase == PH_TRIAL) trial_vec = code_q | onehot;
        else                   trial_vec = '0;
    end

    // Code including the decision being made this cycle
    always_comb begin
        final_code = code_q;
        final_code[bit_idx] = ~cmp_in;
    end
endmodule

// File: rtl/sar_out_stage.sv
// Drives the sampling and array switches and stores the formatted result.
// Assumes load is high for exactly one cycle per conversion.
module sar_out_stage
    import sar_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sar_phase_e       phase,
    input  logic             load,
    input  logic [WIDTH-1:0] trial_vec,
    input  logic [WIDTH-1:0] final_code,
    output logic             samp_close,
    output logic             in_connect,
    output logic [WIDTH-1:0] arr_p,
    output logic [WIDTH-1:0] arr_n,
    output logic [WIDTH-1:0] result
);
    logic [WIDTH-1:0] result_q;

    // Turn offset binary into two's complement by inverting the MSB
    always_ff @(posedge clk) begin
        if (!rst_n)    result_q <= '0;
        else if (load) result_q <= {~final_code[WIDTH-1], final_code[WIDTH-2:0]};
    end

    // Switch drive: sample while idle, open the comparator side first, then trial
    always_comb begin
        samp_close = (phase == PH_ACQ);
        in_connect = (phase != PH_TRIAL);
        arr_p      = trial_vec;
        arr_n      = (phase == PH_TRIAL) ? ~trial_vec : '0;
    end

    assign result = result_q;
endmodule

// File: rtl/sar_diff_ctrl.sv
// Top of the differential SAR conversion controller.
// Assumes conv_n and cmp_in are synchronous to clk.
module sar_diff_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_n,
    input  logic             cmp_in,
    output logic             samp_close,
    output logic             in_connect,
    output logic [WIDTH-1:0] arr_p,
    output logic [WIDTH-1:0] arr_n,
    output logic             busy,
    output logic [WIDTH-1:0] result
);
    logic             fall;
    sar_phase_e       phase;
    logic [IDX_W-1:0] bit_idx;
    logic             last_trial;
    logic [WIDTH-1:0] trial_vec;
    logic [WIDTH-1:0] final_code;

    sar_fall_detect u_fall (
        .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .fall(fall)
    );

    sar_sequencer #(.WIDTH(WIDTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(fall),
        .phase(phase), .bit_idx(bit_idx), .last_trial(last_trial)
    );

    sar_approx_reg #(.WIDTH(WIDTH)) u_sar (
        .clk(clk), .rst_n(rst_n), .phase(phase), .bit_idx(bit_idx),
        .cmp_in(cmp_in), .trial_vec(trial_vec), .final_code(final_code)
    );

    sar_out_stage #(.WIDTH(WIDTH)) u_out (
        .clk(clk), .rst_n(rst_n), .phase(phase), .load(last_trial),
        .trial_vec(trial_vec), .final_code(final_code),
        .samp_close(samp_close), .in_connect(in_connect),
        .arr_p(arr_p), .arr_n(arr_n), .result(result)
    );

    assign busy = (phase != PH_ACQ);
endmodule

// File: rtl/sar_diff_ctrl_chk.sv
// Port-level properties of the SAR controller, bound to every instance.
module sar_diff_ctrl_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             samp_close,
    input logic             in_connect,
    input logic [WIDTH-1:0] arr_p,
    input logic [WIDTH-1:0] arr_n,
    input logic             busy,
    input logic [WIDTH-1:0] result
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    // R10
    idle_switches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (samp_close && in_connect));

    // R2
    open_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(samp_close) |-> in_connect);

    // R3
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_connect) |-> (arr_p == MSB_ONLY));

    // R5
    mirror_arrays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_connect |-> (arr_n == ~arr_p));

    // R5
    idle_arrays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_connect |-> (arr_p == '0 && arr_n == '0));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(result));
endmodule

bind sar_diff_ctrl sar_diff_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .samp_close(samp_close), .in_connect(in_connect),
    .arr_p(arr_p), .arr_n(arr_n), .busy(busy), .result(result)
);

// File: tb/sar_diff_ctrl_tb_top.sv
module sar_diff_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_n = 1'b1;
    logic        cmp_in;
    logic        samp_close, in_connect, busy;
    logic [15:0] arr_p, arr_n, result;
    int          cur_d = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    int          cycles = 0;

    always #10 clk = ~clk;

    // Comparator model: trial value (offset removed) above the input overshoots
    always_comb cmp_in = (int'(arr_p) - 32768) > cur_d;

    sar_diff_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .cmp_in(cmp_in),
        .samp_close(samp_close), .in_connect(in_connect),
        .arr_p(arr_p), .arr_n(arr_n), .busy(busy), .result(result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int expect_code(input int d);
        int c = d;
        if (c > 32767)  c = 32767;
        if (c < -32768) c = -32768;
        return c & 16'hFFFF;
    endfunction

    // One conversion; glitch_at >= 0 re-requests during that trial (R9)
    task automatic convert(input int d, input int glitch_at);
        int  busy_cyc = 1;
        int  trial = 0;
        bit  mirror_ok = 1;
        bit  step_ok = 1;
        int  prev_trial = 0;
        cur_d = d;
        @(negedge clk) conv_n = 1'b0;
        @(negedge clk);
        check(busy === 1'b1, "R2 busy", busy, 1);
        check(samp_close === 1'b0 && in_connect === 1'b1, "R2 open", {samp_close, in_connect}, 1);
        @(negedge clk);
        check(in_connect === 1'b0 && arr_p === 16'h8000, "R3 msb", arr_p, 16'h8000);
        while (busy === 1'b1 && busy_cyc < 40) begin
            busy_cyc++;
            if (in_connect === 1'b0) begin
                if (arr_n !== ~arr_p) mirror_ok = 0;
                if (trial > 0) begin
                    // R4: previous tentative bit kept iff no overshoot
                    bit keep = !((prev_trial - 32768) > d);
                    if (arr_p[16 - trial] !== keep) step_ok = 0;
                end
                prev_trial = int'(arr_p);
                trial++;
            end
            if (trial == glitch_at) conv_n = 1'b1;
            if (trial == glitch_at + 1) conv_n = 1'b0;
            @(negedge clk);
        end
        check(mirror_ok, "R5 mirror", 0, 1);
        check(step_ok, "R4 keep/clear", 0, 1);
        check(busy_cyc == 17, "R6 busy length", busy_cyc, 17);
        check(samp_close === 1'b1 && in_connect === 1'b1, "R10 idle switches", {samp_close, in_connect}, 3);
        check(result === 16'(expect_code(d)),
              (d > 32767 || d < -32768) ? "R8 saturate" : "R7 code",
              result, expect_code(d));
        conv_n = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog: counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && samp_close === 1'b1 && in_connect === 1'b1, "R1 ctrl", busy, 0);
        check(arr_p === 16'h0 && arr_n === 16'h0 && result === 16'h0, "R1 data", result, 0);

        // Corners: zero, +-1 LSB, full scale, saturation
        convert(0, -1);
        convert(1, -1);
        convert(-1, -1);
        convert(32767, -1);
        convert(-32768, -1);
        convert(32768, -1);
        convert(-32769, -1);
        convert(100000, -1);
        convert(-100000, -1);
        // Sweep across the range
        for (int d = -32768; d <= 32767; d += 509) convert(d, -1);
        for (int b = 0; b < 16; b++) begin
            convert(1 << b, -1);
            convert(-(1 << b), -1);
        end

        // R9: re-request mid conversion changes nothing
        convert(12345, 5);
        convert(-777, 12);
        // R9: holding conv_n low starts no new conversion
        @(negedge clk) conv_n = 1'b0;
        @(negedge clk);
        check(busy === 1'b1, "R9 start", busy, 1);
        while (busy === 1'b1) @(negedge clk);
        repeat (5) @(negedge clk);
        check(busy === 1'b0, "R9 held low no restart", busy, 0);
        conv_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule